// File: doc/BRIEF.md
# Console Memory-Map Bus Decoder

This block sits between the CPU of a small 8-bit console and its memories and peripherals. It decodes each 16-bit CPU address into one of four regions: a 4096-byte program ROM, a 128-byte scratch RAM, a video-chip window and an I/O-chip window. Only a few address bits take part in the decode. All other bits are ignored, so every region repeats across the address space.

The block holds both storage arrays. It returns read data combinationally from the current address. For the two peripheral windows it passes an external read-data bus straight through, and it drives one-hot chip selects and a window offset so that the external chips can be attached directly. The ROM is filled through a dedicated preload port before the CPU starts. A CPU store that lands in ROM is discarded and sets a sticky error flag.

Top module: `console_bus_decoder`

## Requirements
- R1: When address bit 12 is 1, only sel_prog is high, whatever the other bits hold, and a read returns the ROM byte at index addr[11:0].
- R2: When bit 12 is 0 and bit 7 is 0, only sel_vid is high and win_off equals addr[5:0].
- R3: When bit 12 is 0, bit 7 is 1 and bit 9 is 1, only sel_io is high and win_off equals {1'b0, addr[4:0]}. win_off is 0 when neither window is selected.
- R4: When bit 12 is 0, bit 7 is 1 and bit 9 is 0, only sel_ram is high and a read returns the RAM byte at index addr[6:0].
- R5: Exactly one of sel_prog, sel_ram, sel_vid and sel_io is high at all times. The select vector is ordered {sel_prog, sel_ram, sel_vid, sel_io}.
- R6: Bits 15..13, 11..10 and 8 never change the region. RAM addresses that differ only in those bits reach the same byte.
- R7: A CPU write decoded to RAM updates only the addressed byte at the rising clock edge. A read in the next cycle returns the new value, and every other RAM byte keeps its value.
- R8: A CPU write decoded to ROM leaves the ROM contents unchanged and sets rom_wr_err. The flag stays high until reset.
- R9: A read of the video or I/O window returns periph_rdata unchanged.
- R10: Reset clears every RAM byte to 0 and clears rom_wr_err.
- R11: cpu_rdata is 0 whenever cpu_rd is low.
- R12: With ld_en high, ld_data is written into ROM at index ld_addr on the rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rdata | output | 8 | Read data to the CPU |
| periph_rdata | input | 8 | Read data from the selected external chip |
| sel_prog | output | 1 | ROM region selected |
| sel_ram | output | 1 | RAM region selected |
| sel_vid | output | 1 | Video-chip window selected |
| sel_io | output | 1 | I/O-chip window selected |
| win_off | output | 6 | Register offset inside the selected window |
| rom_wr_err | output | 1 | Sticky flag: a CPU store hit ROM |
| ld_en | input | 1 | ROM preload enable |
| ld_addr | input | 12 | ROM preload index |
| ld_data | input | 8 | ROM preload byte |

## Verification
The bench targets addresses where the priority order matters, such as bit 12 set together with RAM or window bits. A decoder that evaluated RAM or a window first would assert the wrong select there. Mirrored RAM addresses are written through one alias and read through another. An index that kept an ignored bit would then miss the byte. A RAM write is checked against its neighbours, which a wrong index or a whole-word update would corrupt. A store into ROM is followed by a read-back of that ROM byte and by checks that the error flag stays set until reset, so a ROM that accepted CPU stores, or a flag that was not sticky, would be caught.

// File: rtl/cbd_pkg.sv
package cbd_pkg;
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int ROM_AW    = 12;
    localparam int RAM_AW    = 7;
    localparam int ROM_BIT   = 12;
    localparam int WIN_BIT   = 7;
    localparam int IO_BIT    = 9;
    localparam int VID_OFF_W = 6;
    localparam int IO_OFF_W  = 5;
    localparam int NUM_REG   = 4;

    typedef enum logic [1:0] {
        REG_PROG = 2'd0,
        REG_VID  = 2'd1,
        REG_IO   = 2'd2,
        REG_RAM  = 2'd3
    } region_e;
endpackage

// File: rtl/cbd_decode.sv
module cbd_decode
    import cbd_pkg::*;
#(
    parameter int AW    = ADDR_W,
    parameter int OFF_W = VID_OFF_W
) (
    input  logic [AW-1:0]    addr,
    output region_e          region,
    output logic [OFF_W-1:0] off
);
    // Priority: program store, video window, I/O window, RAM.
    always_comb begin
        off = '0;
        if (addr[ROM_BIT]) begin
            region = REG_PROG;
        end else if (!addr[WIN_BIT]) begin
            region = REG_VID;
            off    = addr[VID_OFF_W-1:0];
        end else if (addr[IO_BIT]) begin
            region = REG_IO;
            off[IO_OFF_W-1:0] = addr[IO_OFF_W-1:0];
        end else begin
            region = REG_RAM;
        end
    end
endmodule

// File: rtl/cbd_rom.sv
module cbd_rom
    import cbd_pkg::*;
#(
    parameter int AW = ROM_AW,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          ld_en,
    input  logic [AW-1:0] ld_addr,
    input  logic [DW-1:0] ld_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    // Only the preload port writes; CPU stores never reach this array.
    always_ff @(posedge clk) begin
        if (ld_en) mem_q[ld_addr] <= ld_data;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/cbd_ram.sv
module cbd_ram
    import cbd_pkg::*;
#(
    parameter int AW = RAM_AW,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] idx,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_d [DEPTH];
    logic [DW-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[idx] = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) mem_q <= '{default: '0};
        else        mem_q <= mem_d;
    end

    assign rdata = mem_q[idx];
endmodule

// File: rtl/console_bus_decoder.sv
module console_bus_decoder
    import cbd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    cpu_addr,
    input  logic [DATA_W-1:0]    cpu_wdata,
    input  logic                 cpu_rd,
    input  logic                 cpu_wr,
    output logic [DATA_W-1:0]    cpu_rdata,
    input  logic [DATA_W-1:0]    periph_rdata,
    output logic                 sel_prog,
    output logic                 sel_ram,
    output logic                 sel_vid,
    output logic                 sel_io,
    output logic [VID_OFF_W-1:0] win_off,
    output logic                 rom_wr_err,
    input  logic                 ld_en,
    input  logic [ROM_AW-1:0]    ld_addr,
    input  logic [DATA_W-1:0]    ld_data
);
    typedef struct packed {
        logic rom_wr_err;
    } state_t;

    state_t        st_d, st_q;
    region_e       region;
    logic [NUM_REG-1:0] sel_vec;
    logic [DATA_W-1:0] rom_rd, ram_rd;

    cbd_decode #(.AW(ADDR_W), .OFF_W(VID_OFF_W)) u_dec (
        .addr   (cpu_addr),
        .region (region),
        .off    (win_off)
    );

    // One select per region, indexed by the enum value.
    for (genvar g = 0; g < NUM_REG; g++) begin : g_sel
        assign sel_vec[g] = (region == region_e'(g));
    end
    assign sel_prog = sel_vec[REG_PROG];
    assign sel_vid  = sel_vec[REG_VID];
    assign sel_io   = sel_vec[REG_IO];
    assign sel_ram  = sel_vec[REG_RAM];

    cbd_rom #(.AW(ROM_AW), .DW(DATA_W)) u_rom (
        .clk     (clk),
        .ld_en   (ld_en),
        .ld_addr (ld_addr),
        .ld_data (ld_data),
        .rd_addr (cpu_addr[ROM_AW-1:0]),
        .rd_data (rom_rd)
    );

    cbd_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cpu_wr && sel_ram),
        .idx   (cpu_addr[RAM_AW-1:0]),
        .wdata (cpu_wdata),
        .rdata (ram_rd)
    );

    always_comb begin
        st_d = st_q;
        if (cpu_wr && sel_prog) st_d.rom_wr_err = 1'b1;

        cpu_rdata = '0;
        if (cpu_rd) begin
            unique case (region)
                REG_PROG: cpu_rdata = rom_rd;
                REG_RAM:  cpu_rdata = ram_rd;
                default:  cpu_rdata = periph_rdata;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rom_wr_err = st_q.rom_wr_err;
endmodule

// File: rtl/cbd_checker.sv
module cbd_checker
    import cbd_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    cpu_addr,
    input logic [DATA_W-1:0]    cpu_wdata,
    input logic                 cpu_rd,
    input logic                 cpu_wr,
    input logic [DATA_W-1:0]    cpu_rdata,
    input logic [DATA_W-1:0]    periph_rdata,
    input logic                 sel_prog,
    input logic                 sel_ram,
    input logic                 sel_vid,
    input logic                 sel_io,
    input logic [VID_OFF_W-1:0] win_off,
    input logic                 rom_wr_err
);
    assert_onehot_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sel_prog, sel_ram, sel_vid, sel_io}) == 1);

    assert_rom_priority_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_addr[ROM_BIT] |-> sel_prog);

    assert_vid_offset_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_vid |-> (win_off == cpu_addr[VID_OFF_W-1:0]));

    assert_io_offset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_io |-> (win_off == {1'b0, cpu_addr[IO_OFF_W-1:0]}));

    assert_periph_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && (sel_vid || sel_io)) |-> (cpu_rdata == periph_rdata));

    assert_idle_rdata_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_rd |-> (cpu_rdata == '0));

    assert_err_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr[ROM_BIT]) |=> rom_wr_err);

    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rom_wr_err |=> rom_wr_err);

    assert_ram_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpu_wr && sel_ram) && cpu_rd && sel_ram
         && cpu_addr[RAM_AW-1:0] == $past(cpu_addr[RAM_AW-1:0]))
        |-> (cpu_rdata == $past(cpu_wdata)));
endmodule

bind console_bus_decoder cbd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .cpu_rd       (cpu_rd),
    .cpu_wr       (cpu_wr),
    .cpu_rdata    (cpu_rdata),
    .periph_rdata (periph_rdata),
    .sel_prog     (sel_prog),
    .sel_ram      (sel_ram),
    .sel_vid      (sel_vid),
    .sel_io       (sel_io),
    .win_off      (win_off),
    .rom_wr_err   (rom_wr_err)
);

// File: tb/console_bus_decoder_bench.sv
module console_bus_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;
    logic [7:0]  periph_rdata = '0;
    logic        sel_prog, sel_ram, sel_vid, sel_io;
    logic [5:0]  win_off;
    logic        rom_wr_err;
    logic        ld_en = 1'b0;
    logic [11:0] ld_addr = '0;
    logic [7:0]  ld_data = '0;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_ram [128];

    always #5ns clk = ~clk;

    console_bus_decoder u_console_bus_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .periph_rdata(periph_rdata), .sel_prog(sel_prog), .sel_ram(sel_ram),
        .sel_vid(sel_vid), .sel_io(sel_io), .win_off(win_off),
        .rom_wr_err(rom_wr_err), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    // Vector: address, expected {prog,ram,vid,io}, expected window offset.
    typedef struct packed {
        logic [15:0] addr;
        logic [3:0]  sel;
        logic [5:0]  off;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VECS [NV] = '{
        '{16'h1000, 4'b1000, 6'h00},
        '{16'hF123, 4'b1000, 6'h00},
        '{16'h1E80, 4'b1000, 6'h00},
        '{16'h0000, 4'b0010, 6'h00},
        '{16'h0E7F, 4'b0010, 6'h3F},
        '{16'h0040, 4'b0010, 6'h00},
        '{16'h0080, 4'b0100, 6'h00},
        '{16'hED80, 4'b0100, 6'h00},
        '{16'h0280, 4'b0001, 6'h00},
        '{16'h02FF, 4'b0001, 6'h1F},
        '{16'hE3E5, 4'b0001, 6'h05},
        '{16'h6DFF, 4'b0100, 6'h00}
    };

    function automatic logic [7:0] rom_pat(input logic [11:0] a);
        logic [15:0] t;
        t = a * 16'd7 + 16'd3;
        return t[7:0] ^ {4'h0, a[11:8]};
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    task automatic cpu_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1ns d = cpu_rdata;
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1; cpu_rd = 1'b0;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    initial begin
        #2ms;
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1ns;
        // R10 / R11: reset state
        check("R10 err after reset", 16'(rom_wr_err), 16'h0);
        check("R11 rdata idle", 16'(cpu_rdata), 16'h0);

        // R12: preload the whole ROM
        for (int i = 0; i < 4096; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_addr = 12'(i); ld_data = rom_pat(12'(i));
        end
        @(negedge clk);
        ld_en = 1'b0;

        // R1..R6 decode table
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            cpu_addr = VECS[v].addr; cpu_rd = 1'b0;
            #1ns;
            check("R5 select vector", 16'({sel_prog, sel_ram, sel_vid, sel_io}), 16'(VECS[v].sel));
            check("R2/R3 window offset", 16'(win_off), 16'(VECS[v].off));
        end

        // R1 / R12: ROM reads including mirrored upper bits
        cpu_read(16'h1000, d); check("R1 rom 000", 16'(d), 16'(rom_pat(12'h000)));
        cpu_read(16'hFABC, d); check("R1 rom ABC", 16'(d), 16'(rom_pat(12'hABC)));
        cpu_read(16'h1FFF, d); check("R12 rom FFF", 16'(d), 16'(rom_pat(12'hFFF)));

        // R10: RAM cleared by reset
        for (int i = 0; i < 128; i++) exp_ram[i] = 8'h00;
        cpu_read(16'h00A5, d); check("R10 ram zero", 16'(d), 16'h0);

        // R7 / R4: write then read next cycle, neighbours untouched
        cpu_write(16'h0085, 8'h5A); exp_ram[5] = 8'h5A;
        cpu_read(16'h0085, d); check("R7 readback", 16'(d), 16'h5A);
        cpu_read(16'h0084, d); check("R7 neighbour low", 16'(d), 16'h00);
        cpu_read(16'h0086, d); check("R7 neighbour high", 16'(d), 16'h00);
        // R6: write via one alias, read via another
        cpu_write(16'hED80, 8'hC3); exp_ram[0] = 8'hC3;
        cpu_read(16'h0080, d); check("R6 alias read", 16'(d), 16'hC3);
        cpu_write(16'h01FF, 8'h77); exp_ram[127] = 8'h77;
        cpu_read(16'hEDFF, d); check("R4 top byte", 16'(d), 16'h77);
        cpu_read(16'h6C85, d); check("R6 mirror idx5", 16'(d), 16'(exp_ram[5]));

        // R9: peripheral pass-through
        periph_rdata = 8'h3C;
        cpu_read(16'h0012, d); check("R9 video read", 16'(d), 16'h3C);
        periph_rdata = 8'hA7;
        cpu_read(16'h0291, d); check("R9 io read", 16'(d), 16'hA7);

        // R11: no read strobe gives zero
        @(negedge clk); cpu_addr = 16'h0085; cpu_rd = 1'b0; #1ns;
        check("R11 no strobe", 16'(cpu_rdata), 16'h0);

        // R8: store into ROM ignored, error sticky
        check("R8 err before", 16'(rom_wr_err), 16'h0);
        cpu_write(16'h1ABC, 8'hFF);
        cpu_read(16'h1ABC, d); check("R8 rom unchanged", 16'(d), 16'(rom_pat(12'hABC)));
        check("R8 err set", 16'(rom_wr_err), 16'h1);
        cpu_read(16'h0085, d); check("R8 ram untouched", 16'(d), 16'h5A);
        repeat (5) @(negedge clk);
        #1ns check("R8 err sticky", 16'(rom_wr_err), 16'h1);

        // R10: reset clears RAM and flag
        @(negedge clk); rst_n = 1'b0; cpu_rd = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1ns check("R10 err cleared", 16'(rom_wr_err), 16'h0);
        cpu_read(16'h0085, d); check("R10 ram cleared 5", 16'(d), 16'h0);
        cpu_read(16'h0080, d); check("R10 ram cleared 0", 16'(d), 16'h0);
        cpu_read(16'h1ABC, d); check("R1 rom kept over reset", 16'(d), 16'(rom_pat(12'hABC)));

        @(negedge clk); cpu_rd = 1'b0;
        finish_run();
    end
endmodule